// File: doc/BRIEF.md
# Cascadable Synchronous Presettable Counter

This block is a synchronous binary counter assembled from identical narrow stages. Each stage has a parallel load, a clear, two count enables and a carry output. The stages are chained inside the block: the carry of each stage drives the carry-side enable of the stage above it. All stages share one clock, one load-side enable, one load and one clear, so the chain behaves as a single wide binary counter. Clear, load and counting act only on the rising clock edge. Clear wins over load, and load wins over counting.

A mode input turns the counter into a divide-by-N counter without any outside logic. In reload mode, the terminal count loads a preset value, so the counter runs from the preset up to all ones and then repeats. In match mode, a chosen decoded count clears the counter on the next edge, so it runs from zero up to that value. With the default parameters (two 4-bit stages, preset 245, match value 10), both modes divide by 11.

Top module: `presettable_counter`

## Requirements
- R1: When `clr` is high at a rising edge, `count` becomes 0 on that edge, whatever `load`, `enp`, `ent`, `mode` and `din` are.
- R2: When `clr` is low and `load` is high at a rising edge, `count` becomes `din` on that edge and does not count. The one exception is the match-mode auto-clear in R8.
- R3: When `clr` and `load` are low and `enp` and `ent` are both high, `count` increments by one on the edge. In binary mode (`mode` = 0), all ones wraps to 0.
- R4: When `clr` and `load` are low and either `enp` or `ent` is low, `count` holds its value. This applies in every mode.
- R5: `rco` is high exactly when `ent` is high and `count` is all ones. It follows the current state and `ent` in the same cycle, and `enp` has no effect on it.
- R6: The stages count together as one binary counter of STAGE_W*STAGES bits. A carry moves across every stage boundary on the same edge (for example 0x0F to 0x10, and 0xFF to 0x00).
- R7: In reload mode (`mode` = 1), a counting edge (`enp` and `ent` high, `clr` and `load` low) at all ones loads RELOAD_VAL. An external load still takes `din`. With the defaults, the sequence is 245..255 and then repeats (period 11).
- R8: In match mode (`mode` = 2), a counting edge (`enp` and `ent` high) while `count` equals CLEAR_AT clears the counter with clear priority, overriding `load`. With the defaults, the sequence is 0..10 and then repeats (period 11). If either enable is low, no auto-clear occurs.
- R9: `mode` = 3 behaves exactly like binary mode, with no auto-reload and no auto-clear.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| clr | input | 1 | Synchronous clear, active high, highest priority |
| load | input | 1 | Synchronous parallel load, active high |
| enp | input | 1 | Count enable shared by all stages; does not gate the carry |
| ent | input | 1 | Count enable into the lowest stage; gates the carry |
| mode | input | 2 | 0 binary, 1 reload at terminal count, 2 clear at match, 3 binary |
| din | input | STAGE_W*STAGES | Parallel load data |
| count | output | STAGE_W*STAGES | Current count |
| rco | output | 1 | Ripple carry out of the top stage |

## Verification
The bench targets the priority corners. It drives clear together with load and enables, and load together with enables at all ones. A design with the wrong priority order would load, or count, instead. It separates the two enables around all ones. If the carry were gated by `enp`, `rco` would drop while `enp` is low, and a carry that ignores `ent` would stay high while `ent` is low. Both divide-by-11 modes are run for full periods. The tests also cover the external load that must win over an auto-reload, the auto-clear that must win over a load, and the auto-clear that must not fire while counting is disabled. A free run of more than 256 cycles exposes any carry lost at the stage boundary and any wrong wrap.

// File: rtl/cnt_pkg.sv
package cnt_pkg;
   typedef enum logic [1:0] {
      MODE_BIN    = 2'd0,
      MODE_RELOAD = 2'd1,
      MODE_MATCH  = 2'd2,
      MODE_BIN2   = 2'd3
   } cnt_mode_e;
endpackage

// File: rtl/cnt_stage.sv
module cnt_stage #(
   parameter int W = 4
) (
   input  logic         clk,
   input  logic         clr,
   input  logic         ld,
   input  logic         enp,
   input  logic         ent,
   input  logic [W-1:0] d,
   output logic [W-1:0] q,
   output logic         rco
);
   localparam logic [W-1:0] TERM = {W{1'b1}};

   logic [W-1:0] q_r;
   logic [W-1:0] q_nxt;

   always_comb begin
      if (clr)
         q_nxt = '0;
      else if (ld)
         q_nxt = d;
      else if (enp && ent)
         q_nxt = q_r + {{(W-1){1'b0}}, 1'b1};
      else
         q_nxt = q_r;
   end

   always_ff @(posedge clk) begin
      q_r <= q_nxt;
   end

   assign q   = q_r;
   assign rco = ent && (q_r == TERM);
endmodule

// File: rtl/cnt_chain.sv
module cnt_chain #(
   parameter int STAGE_W = 4,
   parameter int STAGES  = 2
) (
   input  logic                       clk,
   input  logic                       clr,
   input  logic                       ld,
   input  logic                       enp,
   input  logic                       ent,
   input  logic [STAGE_W*STAGES-1:0]  d,
   output logic [STAGE_W*STAGES-1:0]  q,
   output logic                       rco
);
   logic [STAGES:0] carry;

   assign carry[0] = ent;

   for (genvar i = 0; i < STAGES; i++) begin : g_stage
      cnt_stage #(.W(STAGE_W)) u_stage (
         .clk (clk),
         .clr (clr),
         .ld  (ld),
         .enp (enp),
         .ent (carry[i]),
         .d   (d[i*STAGE_W +: STAGE_W]),
         .q   (q[i*STAGE_W +: STAGE_W]),
         .rco (carry[i+1])
      );
   end

   assign rco = carry[STAGES];
endmodule

// File: rtl/cnt_modctl.sv
module cnt_modctl
   import cnt_pkg::*;
#(
   parameter int W          = 8,
   parameter int RELOAD_VAL = 245,
   parameter int CLEAR_AT   = 10
) (
   input  logic [1:0]   mode,
   input  logic         clr,
   input  logic         load,
   input  logic         enp,
   input  logic         ent,
   input  logic [W-1:0] din,
   input  logic [W-1:0] count,
   output logic         clr_eff,
   output logic         ld_eff,
   output logic [W-1:0] d_eff
);
   localparam logic [W-1:0] RELOAD_W = W'(RELOAD_VAL);
   localparam logic [W-1:0] MATCH_W  = W'(CLEAR_AT);
   localparam logic [W-1:0] TERM     = {W{1'b1}};

   cnt_mode_e m;
   logic      run;
   logic      at_term;
   logic      at_match;

   assign m        = cnt_mode_e'(mode);
   assign run      = enp && ent;
   assign at_term  = (count == TERM);
   assign at_match = (count == MATCH_W);

   always_comb begin
      clr_eff = clr;
      ld_eff  = load;
      d_eff   = din;
      case (m)
         MODE_RELOAD: begin
            ld_eff = load || (at_term && run);
            d_eff  = load ? din : RELOAD_W;
         end
         MODE_MATCH: begin
            clr_eff = clr || (at_match && run);
         end
         default: ;
      endcase
   end
endmodule

// File: rtl/presettable_counter.sv
module presettable_counter #(
   parameter int STAGE_W    = 4,
   parameter int STAGES     = 2,
   parameter int RELOAD_VAL = 245,
   parameter int CLEAR_AT   = 10
) (
   input  logic                      clk,
   input  logic                      clr,
   input  logic                      load,
   input  logic                      enp,
   input  logic                      ent,
   input  logic [1:0]                mode,
   input  logic [STAGE_W*STAGES-1:0] din,
   output logic [STAGE_W*STAGES-1:0] count,
   output logic                      rco
);
   localparam int W = STAGE_W * STAGES;

   if (STAGE_W < 1) begin : g_bad_stage_w
      $error("STAGE_W must be at least 1");
   end
   if (STAGES < 1) begin : g_bad_stages
      $error("STAGES must be at least 1");
   end
   if (W > 30) begin : g_bad_width
      $error("total width must not exceed 30 bits");
   end
   if (RELOAD_VAL < 0 || RELOAD_VAL >= (1 << W)) begin : g_bad_reload
      $error("RELOAD_VAL does not fit the counter width");
   end
   if (CLEAR_AT < 0 || CLEAR_AT >= (1 << W)) begin : g_bad_match
      $error("CLEAR_AT does not fit the counter width");
   end

   logic         clr_eff;
   logic         ld_eff;
   logic [W-1:0] d_eff;

   cnt_modctl #(
      .W          (W),
      .RELOAD_VAL (RELOAD_VAL),
      .CLEAR_AT   (CLEAR_AT)
   ) u_modctl (
      .mode    (mode),
      .clr     (clr),
      .load    (load),
      .enp     (enp),
      .ent     (ent),
      .din     (din),
      .count   (count),
      .clr_eff (clr_eff),
      .ld_eff  (ld_eff),
      .d_eff   (d_eff)
   );

   cnt_chain #(
      .STAGE_W (STAGE_W),
      .STAGES  (STAGES)
   ) u_chain (
      .clk (clk),
      .clr (clr_eff),
      .ld  (ld_eff),
      .enp (enp),
      .ent (ent),
      .d   (d_eff),
      .q   (count),
      .rco (rco)
   );
endmodule

// File: rtl/presettable_counter_chk.sv
module presettable_counter_chk #(
   parameter int STAGE_W    = 4,
   parameter int STAGES     = 2,
   parameter int RELOAD_VAL = 245,
   parameter int CLEAR_AT   = 10
) (
   input logic                      clk,
   input logic                      clr,
   input logic                      load,
   input logic                      enp,
   input logic                      ent,
   input logic [1:0]                mode,
   input logic [STAGE_W*STAGES-1:0] din,
   input logic [STAGE_W*STAGES-1:0] count,
   input logic                      rco
);
   localparam int W = STAGE_W * STAGES;
   localparam logic [W-1:0] ONES = {W{1'b1}};

   logic armed = 1'b0;
   always_ff @(posedge clk) armed <= armed || clr;

   logic run;
   logic auto_clr;
   assign run      = enp && ent;
   assign auto_clr = (mode == 2'd2) && run && (count == W'(CLEAR_AT));

   AST_CLR_ZERO: assert property (@(posedge clk) clr |=> count == '0); // R1
   AST_LOAD_DIN: assert property (@(posedge clk) disable iff (!armed)
      (!clr && load && !auto_clr) |=> count == $past(din)); // R2
   AST_COUNT_UP: assert property (@(posedge clk) disable iff (!armed)
      (!clr && !load && run && (mode == 2'd0 || mode == 2'd3))
      |=> count == W'($past(count) + 1)); // R3
   AST_HOLD: assert property (@(posedge clk) disable iff (!armed)
      (!clr && !load && !run) |=> $stable(count)); // R4
   AST_RCO_NEEDS_ENT: assert property (@(posedge clk) disable iff (!armed)
      rco |-> ent); // R5
   AST_RCO_AT_TERM: assert property (@(posedge clk) disable iff (!armed)
      (ent && count == ONES) |-> rco); // R5
   AST_RELOAD: assert property (@(posedge clk) disable iff (!armed)
      (!clr && !load && run && mode == 2'd1 && count == ONES)
      |=> count == W'(RELOAD_VAL)); // R7
   AST_MATCH_CLR: assert property (@(posedge clk) disable iff (!armed)
      auto_clr |=> count == '0); // R8
endmodule

bind presettable_counter presettable_counter_chk #(
   .STAGE_W    (STAGE_W),
   .STAGES     (STAGES),
   .RELOAD_VAL (RELOAD_VAL),
   .CLEAR_AT   (CLEAR_AT)
) u_chk (
   .clk   (clk),
   .clr   (clr),
   .load  (load),
   .enp   (enp),
   .ent   (ent),
   .mode  (mode),
   .din   (din),
   .count (count),
   .rco   (rco)
);

// File: tb/sim_presettable_counter.sv
module sim_presettable_counter;
   localparam int CLK_P = 10;
   localparam int W = 8;
   localparam int NV = 23;

   logic         clk = 1'b0;
   logic         clr = 1'b0;
   logic         load = 1'b0;
   logic         enp = 1'b0;
   logic         ent = 1'b0;
   logic [1:0]   mode = 2'd0;
   logic [W-1:0] din = '0;
   logic [W-1:0] count;
   logic         rco;

   int checks = 0;
   int fails  = 0;

   presettable_counter u0 (
      .clk (clk), .clr (clr), .load (load), .enp (enp), .ent (ent),
      .mode (mode), .din (din), .count (count), .rco (rco)
   );

   always #(CLK_P/2) clk = ~clk;

   // {clr, load, enp, ent, mode[1:0], din[7:0], exp_count[7:0], exp_rco}
   localparam logic [22:0] VEC [0:NV-1] = '{
      {4'b1111, 2'd0, 8'h55, 8'h00, 1'b0}, // R1 clear beats load and count
      {4'b0111, 2'd0, 8'hFE, 8'hFE, 1'b0}, // R2 load beats count
      {4'b0011, 2'd0, 8'h00, 8'hFF, 1'b1}, // R3 R5 count to all ones
      {4'b0011, 2'd0, 8'h00, 8'h00, 1'b0}, // R3 wrap
      {4'b0111, 2'd0, 8'h0F, 8'h0F, 1'b0}, // R2
      {4'b0011, 2'd0, 8'h00, 8'h10, 1'b0}, // R6 stage boundary carry
      {4'b0001, 2'd0, 8'h00, 8'h10, 1'b0}, // R4 enp low holds
      {4'b0101, 2'd0, 8'hFF, 8'hFF, 1'b1}, // R2 load without enp
      {4'b0001, 2'd0, 8'h00, 8'hFF, 1'b1}, // R5 carry ignores enp
      {4'b0010, 2'd0, 8'h00, 8'hFF, 1'b0}, // R5 R4 ent low kills carry, holds
      {4'b0011, 2'd1, 8'h00, 8'hF5, 1'b0}, // R7 reload at terminal
      {4'b0011, 2'd1, 8'h00, 8'hF6, 1'b0}, // R7
      {4'b0111, 2'd1, 8'hFF, 8'hFF, 1'b1}, // R7 set terminal
      {4'b0111, 2'd1, 8'h33, 8'h33, 1'b0}, // R7 external load wins
      {4'b0111, 2'd2, 8'h09, 8'h09, 1'b0}, // R8
      {4'b0011, 2'd2, 8'h00, 8'h0A, 1'b0}, // R8
      {4'b0011, 2'd2, 8'h00, 8'h00, 1'b0}, // R8 auto clear
      {4'b0111, 2'd2, 8'h0A, 8'h0A, 1'b0}, // R8
      {4'b0111, 2'd2, 8'h77, 8'h00, 1'b0}, // R8 auto clear beats load
      {4'b0111, 2'd3, 8'hFF, 8'hFF, 1'b1}, // R9
      {4'b0011, 2'd3, 8'h00, 8'h00, 1'b0}, // R9 plain wrap
      {4'b0101, 2'd2, 8'h0A, 8'h0A, 1'b0}, // R8
      {4'b0001, 2'd2, 8'h00, 8'h0A, 1'b0}  // R8 R4 no auto clear when disabled
   };
   localparam int VREQ [0:NV-1] = '{1,2,3,3,2,6,4,2,5,5,7,7,7,7,8,8,8,8,8,9,9,8,8};

   task automatic chk(input string req, input logic [W-1:0] ec, input logic er);
      checks++;
      if (count !== ec || rco !== er) begin
         fails++;
         $display("FAIL %s count=%02h rco=%0b expected count=%02h rco=%0b",
                  req, count, rco, ec, er);
      end
   endtask

   task automatic step(input logic c, input logic l, input logic p, input logic t,
                       input logic [1:0] m, input logic [W-1:0] d);
      @(negedge clk);
      clr = c; load = l; enp = p; ent = t; mode = m; din = d;
      @(posedge clk);
      #1;
   endtask

   initial begin
      #(CLK_P * 200000);
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      logic [W-1:0] e;
      // reset state: R1
      step(1'b1, 1'b0, 1'b0, 1'b0, 2'd0, 8'h00);
      chk("R1", 8'h00, 1'b0);

      for (int i = 0; i < NV; i++) begin
         logic [22:0] v;
         v = VEC[i];
         step(v[22], v[21], v[20], v[19], v[18:17], v[16:9]);
         chk($sformatf("R%0d", VREQ[i]), v[8:1], v[0]);
      end

      // R7 full reload periods
      step(1'b0, 1'b1, 1'b0, 1'b1, 2'd1, 8'hF5);
      e = 8'hF5;
      for (int k = 0; k < 22; k++) begin
         step(1'b0, 1'b0, 1'b1, 1'b1, 2'd1, 8'h00);
         e = (e == 8'hFF) ? 8'hF5 : e + 8'd1;
         chk("R7", e, e == 8'hFF);
      end

      // R8 full match periods
      step(1'b1, 1'b0, 1'b0, 1'b0, 2'd2, 8'h00);
      e = 8'h00;
      for (int k = 0; k < 22; k++) begin
         step(1'b0, 1'b0, 1'b1, 1'b1, 2'd2, 8'h00);
         e = (e == 8'h0A) ? 8'h00 : e + 8'd1;
         chk("R8", e, 1'b0);
      end

      // R6 free run over the whole range
      step(1'b0, 1'b1, 1'b0, 1'b1, 2'd0, 8'hF0);
      e = 8'hF0;
      for (int k = 0; k < 300; k++) begin
         step(1'b0, 1'b0, 1'b1, 1'b1, 2'd0, 8'h00);
         e = e + 8'd1;
         chk("R6", e, e == 8'hFF);
      end

      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule